// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block sits at the input of the execute stage of a five-stage integer pipeline (fetch, decode, execute, memory access, write-back). It replaces each of the two source operands read from the register file with a newer result still travelling down the pipeline, so a dependent instruction can run in the cycle right after its producer without a stall. It is purely combinational and holds no state.

For each source operand the block compares the source register index with the destination index of the instruction in the memory-access stage and of the instruction in the write-back stage. A stage is a candidate only if its write enable is set and its destination index is not register zero. The memory-access stage wins when both stages match because it holds the younger result. A value taken from the write-back stage is the loaded word when that instruction is a load, and the computed result otherwise.

A load followed at once by an instruction that uses its result is never presented to this block. The surrounding code guarantees at least one other instruction or bubble between them, so no interlock is built. No-operation instructions, which write register zero, never produce a forwarding match.

Top module: `fwd_select`

## Requirements
- R1: When neither later stage is a valid match for a source index, that operand output equals its register-file input.
- R2: When the memory-access stage has `exm_wen` = 1, `exm_rd` non-zero and `exm_rd` equal to the source index, the operand output equals `exm_res`.
- R3: When only the write-back stage is a valid match (`mwb_wen` = 1, `mwb_rd` non-zero and equal to the source index), the operand output equals the write-back value.
- R4: When both later stages are valid matches for the same source index, the memory-access value `exm_res` is chosen.
- R5: A source index of 0 always yields the register-file input, even when a stage has write enable set and destination 0, as a no-operation does.
- R6: A stage whose write enable is 0 is never forwarded from, whatever its destination index.
- R7: The write-back value is `mwb_ldata` when `mwb_load` = 1 and `mwb_alu` when `mwb_load` = 0.
- R8: The two operands are selected independently. Each output depends only on its own source index and register-file input together with the shared stage inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs1_idx | input | 5 | First source register index |
| rs2_idx | input | 5 | Second source register index |
| rs1_rf | input | 32 | First operand read from the register file |
| rs2_rf | input | 32 | Second operand read from the register file |
| exm_wen | input | 1 | Memory-access stage writes a register |
| exm_rd | input | 5 | Memory-access stage destination index |
| exm_res | input | 32 | Memory-access stage computed result |
| mwb_wen | input | 1 | Write-back stage writes a register |
| mwb_rd | input | 5 | Write-back stage destination index |
| mwb_alu | input | 32 | Write-back stage computed result |
| mwb_load | input | 1 | Write-back stage instruction is a load |
| mwb_ldata | input | 32 | Write-back stage loaded data |
| op_a | output | 32 | Selected first operand |
| op_b | output | 32 | Selected second operand |

## Verification
Directed patterns put a match in only one stage, in both stages, in neither stage, on register zero, and under a cleared write enable. Each pattern separates one branch of the priority from the others. Distinct data values on every input show which source reached the output. The load flag is toggled while the write-back stage matches, which separates loaded data from the computed result. Mixed cases give the two operands different winners in the same vector, which exposes any crosstalk between the operand paths. A randomized sweep over narrow index ranges then compares both outputs against a reference priority function.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input  logic [RAW-1:0]  rs1_idx,
  input  logic [RAW-1:0]  rs2_idx,
  input  logic [XLEN-1:0] rs1_rf,
  input  logic [XLEN-1:0] rs2_rf,
  input  logic            exm_wen,
  input  logic [RAW-1:0]  exm_rd,
  input  logic [XLEN-1:0] exm_res,
  input  logic            mwb_wen,
  input  logic [RAW-1:0]  mwb_rd,
  input  logic [XLEN-1:0] mwb_alu,
  input  logic            mwb_load,
  input  logic [XLEN-1:0] mwb_ldata,
  output logic [XLEN-1:0] op_a,
  output logic [XLEN-1:0] op_b
);
  localparam int NSRC = 2;

  logic [RAW-1:0]  src_idx [NSRC];
  logic [XLEN-1:0] src_rf  [NSRC];
  logic [XLEN-1:0] src_out [NSRC];

  wire            exm_live = exm_wen && (exm_rd != '0);
  wire            mwb_live = mwb_wen && (mwb_rd != '0);
  wire [XLEN-1:0] mwb_val  = mwb_load ? mwb_ldata : mwb_alu;

  assign src_idx[0] = rs1_idx;
  assign src_idx[1] = rs2_idx;
  assign src_rf[0]  = rs1_rf;
  assign src_rf[1]  = rs2_rf;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    wire hit_e = exm_live && (exm_rd == src_idx[i]);
    wire hit_w = mwb_live && (mwb_rd == src_idx[i]);
    assign src_out[i] = hit_e ? exm_res : (hit_w ? mwb_val : src_rf[i]);
  end

  assign op_a = src_out[0];
  assign op_b = src_out[1];
endmodule

// File: rtl/fwd_select_chk.sv
module fwd_select_chk #(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input logic [RAW-1:0]  rs1_idx,
  input logic [RAW-1:0]  rs2_idx,
  input logic [XLEN-1:0] rs1_rf,
  input logic [XLEN-1:0] rs2_rf,
  input logic            exm_wen,
  input logic [RAW-1:0]  exm_rd,
  input logic [XLEN-1:0] exm_res,
  input logic            mwb_wen,
  input logic [RAW-1:0]  mwb_rd,
  input logic [XLEN-1:0] mwb_alu,
  input logic            mwb_load,
  input logic [XLEN-1:0] mwb_ldata,
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b
);
  always_comb begin
    if (rs1_idx == '0) AST_ZERO_SRC_A: assert (op_a == rs1_rf); // R5
    if (rs2_idx == '0) AST_ZERO_SRC_B: assert (op_b == rs2_rf); // R5
    if (exm_wen && exm_rd == rs1_idx && rs1_idx != '0)
      AST_YOUNG_WINS_A: assert (op_a == exm_res); // R4
    if (exm_wen && exm_rd == rs2_idx && rs2_idx != '0)
      AST_YOUNG_WINS_B: assert (op_b == exm_res); // R2
    if (!exm_wen && !mwb_wen) AST_NO_WEN_A: assert (op_a == rs1_rf); // R6
    if (!exm_wen && !mwb_wen) AST_NO_WEN_B: assert (op_b == rs2_rf); // R6
    if (!(exm_wen && exm_rd == rs1_idx) && mwb_wen && mwb_rd == rs1_idx && rs1_idx != '0)
      AST_WB_VALUE_A: assert (op_a == (mwb_load ? mwb_ldata : mwb_alu)); // R7
    if (!(exm_wen && exm_rd == rs1_idx) && !(mwb_wen && mwb_rd == rs1_idx))
      AST_RF_PASS_A: assert (op_a == rs1_rf); // R1
  end
endmodule

bind fwd_select fwd_select_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
  .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rs1_rf(rs1_rf), .rs2_rf(rs2_rf),
  .exm_wen(exm_wen), .exm_rd(exm_rd), .exm_res(exm_res),
  .mwb_wen(mwb_wen), .mwb_rd(mwb_rd), .mwb_alu(mwb_alu),
  .mwb_load(mwb_load), .mwb_ldata(mwb_ldata), .op_a(op_a), .op_b(op_b)
);

// File: tb/sim_fwd_select.sv
module sim_fwd_select;
  logic clk = 0;
  always #2 clk = ~clk;

  logic [4:0]  rs1_idx, rs2_idx, exm_rd, mwb_rd;
  logic [31:0] rs1_rf, rs2_rf, exm_res, mwb_alu, mwb_ldata;
  logic        exm_wen, mwb_wen, mwb_load;
  logic [31:0] op_a, op_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fwd_select u0 (.*);

  localparam logic [31:0] RF_A = 32'hA0A0_0001, RF_B = 32'hB0B0_0002;
  localparam logic [31:0] V_EX = 32'hEEEE_0003, V_ALU = 32'h5555_0004, V_LD = 32'h1D1D_0005;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_sel(logic [4:0] idx, logic [31:0] rf);
    if (idx != 0 && exm_wen && exm_rd == idx) return exm_res;
    if (idx != 0 && mwb_wen && mwb_rd == idx) return mwb_load ? mwb_ldata : mwb_alu;
    return rf;
  endfunction

  task automatic drive(logic [4:0] a, logic [4:0] b, logic ew, logic [4:0] ed,
                       logic ww, logic [4:0] wd, logic ld);
    @(negedge clk);
    rs1_idx = a; rs2_idx = b; rs1_rf = RF_A; rs2_rf = RF_B;
    exm_wen = ew; exm_rd = ed; exm_res = V_EX;
    mwb_wen = ww; mwb_rd = wd; mwb_alu = V_ALU; mwb_load = ld; mwb_ldata = V_LD;
    #1;
  endtask

  task automatic t_idle();
    drive(5'd3, 5'd4, 0, 5'd3, 0, 5'd4, 0);
    chk("R1 idle a", op_a, RF_A);
    chk("R1 idle b", op_b, RF_B);
    drive(5'd3, 5'd4, 1, 5'd7, 1, 5'd8, 0);
    chk("R1 other rd a", op_a, RF_A);
    chk("R1 other rd b", op_b, RF_B);
  endtask

  task automatic t_exm_only();
    drive(5'd9, 5'd2, 1, 5'd9, 0, 5'd0, 0);
    chk("R2 exm a", op_a, V_EX);
    chk("R8 untouched b", op_b, RF_B);
    drive(5'd2, 5'd9, 1, 5'd9, 0, 5'd0, 0);
    chk("R2 exm b", op_b, V_EX);
  endtask

  task automatic t_wb_only();
    drive(5'd6, 5'd6, 0, 5'd6, 1, 5'd6, 0);
    chk("R3 wb a", op_a, V_ALU);
    chk("R3 wb b", op_b, V_ALU);
  endtask

  task automatic t_both();
    drive(5'd12, 5'd12, 1, 5'd12, 1, 5'd12, 1);
    chk("R4 both a", op_a, V_EX);
    chk("R4 both b", op_b, V_EX);
  endtask

  task automatic t_zero();
    drive(5'd0, 5'd0, 1, 5'd0, 1, 5'd0, 0);
    chk("R5 nop a", op_a, RF_A);
    chk("R5 nop b", op_b, RF_B);
  endtask

  task automatic t_wen_off();
    drive(5'd5, 5'd5, 0, 5'd5, 0, 5'd5, 1);
    chk("R6 wen off a", op_a, RF_A);
    drive(5'd5, 5'd5, 0, 5'd5, 1, 5'd5, 0);
    chk("R6 exm wen off falls to wb", op_a, V_ALU);
  endtask

  task automatic t_load();
    drive(5'd11, 5'd11, 0, 5'd0, 1, 5'd11, 1);
    chk("R7 load data a", op_a, V_LD);
    chk("R7 load data b", op_b, V_LD);
    drive(5'd11, 5'd11, 0, 5'd0, 1, 5'd11, 0);
    chk("R7 alu data", op_a, V_ALU);
  endtask

  task automatic t_mixed();
    drive(5'd7, 5'd8, 1, 5'd7, 1, 5'd8, 1);
    chk("R8 mixed a", op_a, V_EX);
    chk("R8 mixed b", op_b, V_LD);
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom), 5'($urandom_range(0, 3)), 1'($urandom));
      chk("R4 rand a", op_a, ref_sel(rs1_idx, rs1_rf));
      chk("R8 rand b", op_b, ref_sel(rs2_idx, rs2_rf));
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_idle(); t_exm_only(); t_wb_only(); t_both(); t_zero();
    t_wen_off(); t_load(); t_mixed(); t_random();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule